// File: doc/BRIEF.md
# Extended External Memory Address Generator

This block forms the external memory address for an 8-bit controller core whose address and data buses have their own pins, apart from the general-purpose ports. Each cycle the core presents an access type and two address bytes. One cycle later the block drives three ports: a low-byte address port, a high-byte address port and a narrow upper port. The low byte has a dedicated port, so no external latch or address/data sharing is needed for it.

The upper port has two modes, set by the top bit of a mode register. In banked mode it carries address bits 19:16, taken from a bank field of that register. The bank applies only to table reads and data-memory accesses, and the port carries zero on every instruction fetch. In select mode it drives active-low chip selects that decode the two top bits of the high address byte. Each select covers a 16 KB window. For data accesses through an 8-bit index register, the high byte comes from a paging register. Both registers are reached through a small special-function-register port with combinational read.

Top module: `xa_top`

## Requirements
- R1: After reset the three address ports read 0, the paging register reads 0x00 and the mode register reads 0x70.
- R2: The mode register sits at SFR address 0xA2. Bit 7 selects the mode (0 banked, 1 select) and bits 3:0 hold the bank. Bits 6:4 always read 1, and writes to them have no effect.
- R3: The paging register sits at SFR address 0xA1. It reads back the last byte written to it.
- R4: A read of any other SFR address drives the hit output low and the read data to 0x00. A write to such an address changes neither register.
- R5: The access type is 2'b00 for a fetch, 2'b01 for a table read, 2'b10 for a data access through the pointer and 2'b11 for a data access through the index. On a fetch the high and low ports carry the two address bytes. In banked mode the upper port carries 0 on a fetch.
- R6: In banked mode, table reads and pointer data accesses put the presented bytes on the high and low ports. Table reads, pointer data accesses and index data accesses all put the bank field on the upper port.
- R7: On an index data access the high port carries the paging register and the low port carries the index byte.
- R8: In select mode the upper port is all ones except one bit, which is low. The low bit is the one numbered by high-address bits 7:6, for every access type.
- R9: While power-down is asserted the low and high ports keep their values. The upper port carries 0 in banked mode. In select mode it carries the select pattern decoded from the held high byte.
- R10: The ports show an access one clock edge after it is presented. They use the register contents as they stood at that edge, so a register write affects accesses from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfrWe | input | 1 | SFR write strobe |
| sfrAddr | input | 8 | SFR address |
| sfrWdata | input | 8 | SFR write data |
| sfrRdata | output | 8 | SFR read data (combinational) |
| sfrHit | output | 1 | High when sfrAddr selects a register of this block |
| accType | input | 2 | Access type code |
| addrHi | input | 8 | High address byte from the core |
| addrLo | input | 8 | Low address byte or index value |
| powerDown | input | 1 | Power-down hold |
| loPort | output | 8 | Low-byte address port |
| hiPort | output | 8 | High-byte address port |
| upPort | output | 4 | Address bits 19:16 or active-low selects |

## Verification
The bench uses the default parameters: 8-bit bytes and a 4-wide upper port. With these the select decode has four outputs of 16 KB each. The bench walks high bytes 0x00, 0x40, 0x80 and 0xC0 so that every select position is driven low once. It also sets nonzero bank values so that a fetch that wrongly carried the bank would show up. Power-down is applied in both modes so that both hold patterns of the upper port are checked.

// File: rtl/xa_pkg.sv
package xa_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_TABLE = 2'b01,
    ACC_DPTR  = 2'b10,
    ACC_INDEX = 2'b11
  } acc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pageWe;
    logic modeWe;
    logic rdPage;
    logic rdMode;
    logic useBank;
    logic useIndex;
    logic hold;
  } xa_ctl_t;
endpackage

// File: rtl/xa_ctrl.sv
module xa_ctrl #(
  parameter int DATA_W = 8,
  parameter logic [7:0] PAGE_SFR = 8'hA1,
  parameter logic [7:0] MODE_SFR = 8'hA2
) (
  input  logic              sfrWe,
  input  logic [7:0]        sfrAddr,
  input  xa_pkg::acc_e      accType,
  input  logic              powerDown,
  output xa_pkg::xa_ctl_t   ctl,
  output logic              sfrHit
);
  import xa_pkg::*;

  logic pageSel, modeSel, dataAcc;

  assign pageSel = (sfrAddr == PAGE_SFR);
  assign modeSel = (sfrAddr == MODE_SFR);
  assign sfrHit  = pageSel | modeSel;

  // bank field applies to table reads and every data-memory access
  assign dataAcc = (accType == ACC_TABLE) | (accType == ACC_DPTR) | (accType == ACC_INDEX);

  always_comb begin
    ctl          = '0;
    ctl.pageWe   = sfrWe & pageSel;
    ctl.modeWe   = sfrWe & modeSel;
    ctl.rdPage   = pageSel;
    ctl.rdMode   = modeSel;
    ctl.hold     = powerDown;
    ctl.useBank  = dataAcc & ~powerDown;
    ctl.useIndex = (accType == ACC_INDEX);
  end
endmodule

// File: rtl/xa_datapath.sv
module xa_datapath #(
  parameter int DATA_W = 8,
  parameter int UP_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  xa_pkg::xa_ctl_t   ctl,
  input  logic [DATA_W-1:0] sfrWdata,
  input  logic [DATA_W-1:0] addrHi,
  input  logic [DATA_W-1:0] addrLo,
  output logic [DATA_W-1:0] sfrRdata,
  output logic [DATA_W-1:0] loPort,
  output logic [DATA_W-1:0] hiPort,
  output logic [UP_W-1:0]   upPort,
  output logic              modeCs,
  output logic [DATA_W-1:0] pageQ
);
  localparam int RSV_W = DATA_W - 1 - UP_W;
  localparam int SEL_W = $clog2(UP_W);

  logic [UP_W-1:0]   bankQ;
  logic [DATA_W-1:0] nextHi;
  logic [DATA_W-1:0] decSrc;
  logic [SEL_W-1:0]  selBits;
  logic [UP_W-1:0]   csPat;
  logic [UP_W-1:0]   bankOut;
  logic [UP_W-1:0]   upNext;
  logic              unusedRsv;

  assign unusedRsv = ^sfrWdata[DATA_W-2:UP_W];

  // software-visible registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ  <= '0;
      modeCs <= 1'b0;
      bankQ  <= '0;
    end else begin
      if (ctl.pageWe) pageQ <= sfrWdata;
      if (ctl.modeWe) begin
        modeCs <= sfrWdata[DATA_W-1];
        bankQ  <= sfrWdata[UP_W-1:0];
      end
    end
  end

  always_comb begin
    if (ctl.rdMode)      sfrRdata = {modeCs, {RSV_W{1'b1}}, bankQ};
    else if (ctl.rdPage) sfrRdata = pageQ;
    else                 sfrRdata = '0;
  end

  // high byte source: paging register during index access
  assign nextHi  = ctl.useIndex ? pageQ : addrHi;
  assign decSrc  = ctl.hold ? hiPort : nextHi;
  assign selBits = decSrc[DATA_W-1 -: SEL_W];

  for (genvar i = 0; i < UP_W; i++) begin : g_cs
    assign csPat[i] = (selBits != SEL_W'(i));
  end

  assign bankOut = ctl.useBank ? bankQ : '0;
  assign upNext  = modeCs ? csPat : bankOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loPort <= '0;
      hiPort <= '0;
      upPort <= '0;
    end else begin
      if (!ctl.hold) begin
        loPort <= addrLo;
        hiPort <= nextHi;
      end
      upPort <= upNext;
    end
  end
endmodule

// File: rtl/xa_top.sv
module xa_top #(
  parameter int DATA_W = 8,
  parameter int UP_W   = 4,
  parameter logic [7:0] PAGE_SFR = 8'hA1,
  parameter logic [7:0] MODE_SFR = 8'hA2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWe,
  input  logic [7:0]        sfrAddr,
  input  logic [DATA_W-1:0] sfrWdata,
  output logic [DATA_W-1:0] sfrRdata,
  output logic              sfrHit,
  input  logic [1:0]        accType,
  input  logic [DATA_W-1:0] addrHi,
  input  logic [DATA_W-1:0] addrLo,
  input  logic              powerDown,
  output logic [DATA_W-1:0] loPort,
  output logic [DATA_W-1:0] hiPort,
  output logic [UP_W-1:0]   upPort
);
  xa_pkg::xa_ctl_t   ctl;
  logic              modeCs;
  logic [DATA_W-1:0] pageQ;

  xa_ctrl #(.DATA_W(DATA_W), .PAGE_SFR(PAGE_SFR), .MODE_SFR(MODE_SFR)) u_ctrl (
    .sfrWe(sfrWe), .sfrAddr(sfrAddr), .accType(xa_pkg::acc_e'(accType)),
    .powerDown(powerDown), .ctl(ctl), .sfrHit(sfrHit)
  );

  xa_datapath #(.DATA_W(DATA_W), .UP_W(UP_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sfrWdata(sfrWdata),
    .addrHi(addrHi), .addrLo(addrLo), .sfrRdata(sfrRdata),
    .loPort(loPort), .hiPort(hiPort), .upPort(upPort),
    .modeCs(modeCs), .pageQ(pageQ)
  );
endmodule

// File: rtl/xa_checks.sv
module xa_checks #(
  parameter int DATA_W = 8,
  parameter int UP_W   = 4,
  parameter logic [7:0] MODE_SFR = 8'hA2
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        sfrAddr,
  input logic [DATA_W-1:0] sfrRdata,
  input logic              sfrHit,
  input logic [1:0]        accType,
  input logic [DATA_W-1:0] addrLo,
  input logic              powerDown,
  input logic [DATA_W-1:0] loPort,
  input logic [DATA_W-1:0] hiPort,
  input logic [UP_W-1:0]   upPort,
  input logic              modeCs,
  input logic [DATA_W-1:0] pageQ
);
  localparam int RSV_W = DATA_W - 1 - UP_W;

  AST_RSV_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (sfrAddr == MODE_SFR) |-> (sfrRdata[DATA_W-2:UP_W] == {RSV_W{1'b1}})); // R2

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !sfrHit |-> (sfrRdata == '0)); // R4

  AST_FETCH_NO_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (accType == 2'b00 && !modeCs) |=> (upPort == '0)); // R5

  AST_INDEX_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (accType == 2'b11 && !powerDown) |=> (hiPort == $past(pageQ) && loPort == $past(addrLo))); // R7

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    modeCs |=> ($countones(~upPort) == 1)); // R8

  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> ($stable(loPort) && $stable(hiPort))); // R9
endmodule

bind xa_top xa_checks #(.DATA_W(DATA_W), .UP_W(UP_W), .MODE_SFR(MODE_SFR)) u_checks (
  .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrRdata(sfrRdata), .sfrHit(sfrHit),
  .accType(accType), .addrLo(addrLo), .powerDown(powerDown), .loPort(loPort),
  .hiPort(hiPort), .upPort(upPort), .modeCs(modeCs), .pageQ(pageQ)
);

// File: tb/xa_top_test.sv
module xa_top_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       sfrWe;
  logic [7:0] sfrAddr, sfrWdata, sfrRdata;
  logic       sfrHit;
  logic [1:0] accType;
  logic [7:0] addrHi, addrLo;
  logic       powerDown;
  logic [7:0] loPort, hiPort;
  logic [3:0] upPort;

  always #10 clk = ~clk;

  xa_top uut (
    .clk(clk), .rstN(rstN), .sfrWe(sfrWe), .sfrAddr(sfrAddr), .sfrWdata(sfrWdata),
    .sfrRdata(sfrRdata), .sfrHit(sfrHit), .accType(accType), .addrHi(addrHi),
    .addrLo(addrLo), .powerDown(powerDown), .loPort(loPort), .hiPort(hiPort),
    .upPort(upPort)
  );

  typedef struct {
    logic [7:0] lo;
    logic [7:0] hi;
    logic [3:0] up;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  // bench mirror of the registers
  logic       mSel  = 1'b0;
  logic [3:0] mBank = 4'h0;
  logic [7:0] mPage = 8'h00;
  logic [7:0] pLo = 8'h00, pHi = 8'h00;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] dec(logic [7:0] hi);
    return ~(4'b0001 << hi[7:6]);
  endfunction

  // driver: present one access and push its expected result
  task automatic access(logic [1:0] t, logic [7:0] hi, logic [7:0] lo, logic pd, string req);
    exp_t e;
    @(negedge clk);
    accType = t; addrHi = hi; addrLo = lo; powerDown = pd;
    if (pd) begin
      e.lo = pLo; e.hi = pHi;
      e.up = mSel ? dec(pHi) : 4'h0;
    end else begin
      e.lo = lo;
      e.hi = (t == 2'b11) ? mPage : hi;
      if (mSel) e.up = dec(e.hi);
      else      e.up = (t == 2'b00) ? 4'h0 : mBank;
    end
    e.req = req;
    pLo = e.lo; pHi = e.hi;
    q.push_back(e);
  endtask

  task automatic sfrWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    sfrWe = 1'b1; sfrAddr = a; sfrWdata = d;
    @(negedge clk);
    sfrWe = 1'b0;
    if (a == 8'hA1) mPage = d;
    if (a == 8'hA2) begin mSel = d[7]; mBank = d[3:0]; end
  endtask

  task automatic sfrRead(logic [7:0] a, logic [7:0] expD, logic expHit, string req);
    @(negedge clk);
    sfrAddr = a;
    #1;
    check(req, sfrRdata, expD);
    check(req, sfrHit, expHit);
  endtask

  // monitor: compare each result one edge after its access
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.req, " lo"}, loPort, e.lo);
        check({e.req, " hi"}, hiPort, e.hi);
        check({e.req, " up"}, upPort, e.up);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; sfrWe = 1'b0; sfrAddr = 8'h00; sfrWdata = 8'h00;
    accType = 2'b00; addrHi = 8'h00; addrLo = 8'h00; powerDown = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 lo", loPort, 8'h00);
    check("R1 hi", hiPort, 8'h00);
    check("R1 up", upPort, 4'h0);
    rstN = 1'b1;
    sfrRead(8'hA2, 8'h70, 1'b1, "R1 mode");
    sfrRead(8'hA1, 8'h00, 1'b1, "R1 page");

    // R4 unmapped read and ignored write
    sfrRead(8'h80, 8'h00, 1'b0, "R4 miss");
    sfrWrite(8'h80, 8'hFF);
    sfrRead(8'hA1, 8'h00, 1'b1, "R4 page untouched");
    sfrRead(8'hA2, 8'h70, 1'b1, "R4 mode untouched");

    // R5 fetch, banked mode, bank 0
    access(2'b00, 8'h9A, 8'h34, 1'b0, "R5 fetch");
    sfrWrite(8'hA2, 8'h05);
    sfrRead(8'hA2, 8'h75, 1'b1, "R2 bank5");
    // R10 first access after write sees new bank
    access(2'b01, 8'h12, 8'h34, 1'b0, "R10 R6 table");
    access(2'b00, 8'hFE, 8'h01, 1'b0, "R5 fetch bank5");
    access(2'b10, 8'hFF, 8'hFF, 1'b0, "R6 dptr");
    sfrWrite(8'hA1, 8'h12);
    sfrRead(8'hA1, 8'h12, 1'b1, "R3 page");
    access(2'b11, 8'hEE, 8'h00, 1'b0, "R7 index 1200");
    access(2'b00, 8'h55, 8'hAA, 1'b0, "R5 fetch");
    sfrWrite(8'hA1, 8'hFF);
    access(2'b11, 8'h00, 8'h7F, 1'b0, "R7 index ff7f");
    // R9 power-down in banked mode
    access(2'b01, 8'h11, 8'h22, 1'b1, "R9 pd banked");
    access(2'b10, 8'h33, 8'h44, 1'b1, "R9 pd banked 2");
    access(2'b00, 8'h00, 8'h00, 1'b0, "R5 wake");

    // R2 select mode, reserved bits written as zero
    sfrWrite(8'hA2, 8'h8A);
    sfrRead(8'hA2, 8'hFA, 1'b1, "R2 sel");
    access(2'b00, 8'h00, 8'h10, 1'b0, "R8 cs0");
    access(2'b01, 8'h40, 8'h20, 1'b0, "R8 cs1");
    access(2'b10, 8'h80, 8'h30, 1'b0, "R8 cs2");
    access(2'b00, 8'hC0, 8'h40, 1'b0, "R8 cs3");
    access(2'b11, 8'h00, 8'h50, 1'b0, "R8 R7 index cs3");
    access(2'b00, 8'h7F, 8'h60, 1'b0, "R8 cs1 top");
    access(2'b01, 8'hC5, 8'h70, 1'b1, "R9 pd sel");
    access(2'b00, 8'h80, 8'h80, 1'b0, "R8 wake");
    sfrWrite(8'hA2, 8'h03);
    access(2'b01, 8'h80, 8'h90, 1'b0, "R10 R6 back to bank");
    access(2'b00, 8'h80, 8'h91, 1'b0, "R5 fetch bank3");

    repeat (3) @(negedge clk);
    check("queue drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule